// File: doc/BRIEF.md
# Progressive GF(2^8) Row-Reduction Decoder

This block recovers the source data of a random linear network code over GF(2^8). Each coded row enters as a byte stream: N coefficient bytes, then K payload bytes. As soon as a row is complete, the block reduces it against the rows it already holds. A row that adds new information is normalised and merged into the store. A row that reduces to zero coefficients is thrown away. The stored rows are kept in reduced row-echelon form at all times, so decoding starts with the very first row. No separate rank test is made.

When N independent rows are held, the coefficient part of the store is the identity matrix. Stored row i then holds original block i. Any stored byte can be read combinationally through a row/column readout port. A one-cycle result pulse reports, for each row, whether it was kept or dropped. A rank count and a done flag show progress. A clear input restarts the whole process.

Back-pressure: a byte moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` falls after the last byte of a row and stays low while that row is reduced. It rises again in the same cycle as the result pulse. While `done` is high, `in_ready` stays low until `clear` is pulsed. A sender may hold `in_valid` high for any length of time without losing or duplicating bytes.

Top module: `gjd_decoder`

## Requirements
- R1: All products use GF(2^8) multiplication reduced by the polynomial x^8+x^4+x^3+x^2+1 (0x11D), and all sums are bytewise XOR. As a result, a row coded as XOR_i c_i*block_i decodes back to block_i.
- R2: Each row is exactly N+K accepted bytes, coefficient column 0 first, then payload byte 0 onward. After the last byte of a row, `in_ready` is low until the cycle in which `res_valid` pulses.
- R3: A row that is linearly independent of the stored rows gives a one-cycle `res_valid` with `res_kept`=1, and `rank` rises by one in that same cycle.
- R4: A row whose coefficients reduce to all zero gives a one-cycle `res_valid` with `res_kept`=0. This covers a combination of stored rows and a row with zero coefficients. `rank` and every stored byte are left unchanged.
- R5: After every kept row, the stored rows 0..rank-1 form a reduced row-echelon form. Each row's leading coefficient is 1. Leading columns rise strictly with row index. Every other stored row has 0 in a leading column.
- R6: When `rank` equals N, `done` is high. Readout of row i then gives coefficient byte i equal to 1, the other coefficients equal to 0, and payload equal to original block i.
- R7: While `done` is high, `in_ready` is low whatever `in_valid` does, and `rank` and the stored rows do not change.
- R8: A `clear` pulse sets `rank` to 0, lowers `done`, and returns `in_ready` high on the next cycle. A `clear` in the same cycle as a merge wins: no `res_valid` pulse appears and `rank` is 0.
- R9: After reset, `rank` is 0, `done` and `res_valid` are low, and `in_ready` is high.
- R10: Decoding begins with the first row. A kept row whose leading coefficient is in column c is scaled so that coefficient becomes 1, and it is inserted in pivot-column order, whatever the arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous restart: drop all stored rows |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte: coefficients, then payload |
| res_valid | output | 1 | One-cycle result pulse for a finished row |
| res_kept | output | 1 | Qualified by res_valid: 1 = row kept, 0 = row dropped |
| rank | output | $clog2(N+1) | Number of stored independent rows |
| done | output | 1 | Rank equals N |
| rd_row | input | $clog2(N) | Readout row index |
| rd_col | input | $clog2(N+K) | Readout column: 0..N-1 coefficients, N..N+K-1 payload |
| rd_data | output | 8 | Stored byte at (rd_row, rd_col) |

## Verification
Two events can land on the same clock edge: a restart request and the merge of a fully reduced row, which would otherwise raise the rank and pulse a result. The bench counts the cycles from the last accepted byte of a fourth row, using the current rank to find the exact merge edge. It places a one-cycle `clear` on that edge. The outcome is correct only if, on the next cycle, rank is 0, done is low, no result pulse is present, and ready is back high. A fresh row sent afterwards must also be kept as rank 1.

// File: rtl/gjd_pkg.sv
package gjd_pkg;
  typedef logic [7:0] gf_t;

  localparam gf_t GF_POLY_LOW = 8'h1D;

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = b;
    for (int i = 0; i < 8; i++) begin
      if (a[i]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ GF_POLY_LOW) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

  // a^-1 = a^254 = product of a^(2^k), k = 1..7
  function automatic gf_t gf_inv(gf_t a);
    gf_t sq;
    gf_t r;
    sq = a;
    r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return (a == '0) ? '0 : r;
  endfunction
endpackage

// File: rtl/gjd_row_mac.sv
module gjd_row_mac #(
  parameter int W = 20
) (
  input  logic [7:0]          factor,
  input  logic [W-1:0][7:0]   src,
  input  logic [W-1:0][7:0]   acc,
  output logic [W-1:0][7:0]   res
);
  import gjd_pkg::*;

  for (genvar b = 0; b < W; b++) begin : g_byte
    assign res[b] = acc[b] ^ gf_mul(factor, src[b]);
  end
endmodule

// File: rtl/gjd_lead_find.sv
module gjd_lead_find #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][7:0] coef,
  output logic              found,
  output logic [IW-1:0]     idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int c = N - 1; c >= 0; c--) begin
      if (coef[c] != 8'h00) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/gjd_decoder.sv
module gjd_decoder #(
  parameter int N = 4,
  parameter int K = 16,
  localparam int W  = N + K,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(W),
  localparam int RW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          res_valid,
  output logic          res_kept,
  output logic [RW-1:0] rank,
  output logic          done,
  input  logic [IW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic [7:0]    rd_data
);
  import gjd_pkg::*;

  typedef enum logic [1:0] {S_LOAD, S_ELIM, S_PIVOT, S_MERGE} st_t;

  st_t                        st_q;
  logic [N-1:0][W-1:0][7:0]   mat_q;
  logic [N-1:0][IW-1:0]       piv_q;
  logic [W-1:0][7:0]          nrow_q;
  logic [CW-1:0]              cnt_q;
  logic [IW-1:0]              jj_q;
  logic [IW-1:0]              lead_q;
  logic [RW-1:0]              rank_q;

  // Step A: reduce the new row by one stored pivot row per cycle
  logic [W-1:0][7:0] elim_row;
  gjd_row_mac #(.W(W)) u_elim (
    .factor (nrow_q[piv_q[jj_q]]),
    .src    (mat_q[jj_q]),
    .acc    (nrow_q),
    .res    (elim_row)
  );

  // Steps B/C: leading nonzero coefficient
  logic          lead_found;
  logic [IW-1:0] lead_idx;
  gjd_lead_find #(.N(N)) u_lead (
    .coef  (nrow_q[N-1:0]),
    .found (lead_found),
    .idx   (lead_idx)
  );

  // Step D: normalise the pivot to 1
  gf_t               inv_v;
  logic [W-1:0][7:0] scaled;
  always_comb begin
    inv_v = gf_inv(nrow_q[lead_idx]);
    for (int b = 0; b < W; b++) scaled[b] = gf_mul(inv_v, nrow_q[b]);
  end

  // Step E: clear the new pivot column in every stored row
  logic [N-1:0][W-1:0][7:0] upd;
  logic [N-1:0][W-1:0][7:0] upd_sh;
  logic [N-1:0][IW-1:0]     piv_sh;
  for (genvar i = 0; i < N; i++) begin : g_row
    gjd_row_mac #(.W(W)) u_back (
      .factor (mat_q[i][lead_q]),
      .src    (nrow_q),
      .acc    (mat_q[i]),
      .res    (upd[i])
    );
    if (i == 0) begin : g_first
      assign upd_sh[i] = '0;
      assign piv_sh[i] = '0;
    end else begin : g_rest
      assign upd_sh[i] = upd[i-1];
      assign piv_sh[i] = piv_q[i-1];
    end
  end

  // Insertion slot keeps rows sorted by pivot column
  int ins_pos;
  always_comb begin
    ins_pos = 0;
    for (int i = 0; i < N; i++)
      if (i < int'(rank_q) && piv_q[i] < lead_q) ins_pos = ins_pos + 1;
  end

  assign done     = (rank_q == RW'(N));
  assign in_ready = (st_q == S_LOAD) && !done;
  assign rank     = rank_q;
  assign rd_data  = mat_q[rd_row][rd_col];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_LOAD;
      mat_q     <= '0;
      piv_q     <= '0;
      nrow_q    <= '0;
      cnt_q     <= '0;
      jj_q      <= '0;
      lead_q    <= '0;
      rank_q    <= '0;
      res_valid <= 1'b0;
      res_kept  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (clear) begin
        st_q   <= S_LOAD;
        cnt_q  <= '0;
        rank_q <= '0;
      end else begin
        unique case (st_q)
          S_LOAD: begin
            if (in_valid && in_ready) begin
              nrow_q[cnt_q] <= in_data;
              if (cnt_q == CW'(W - 1)) begin
                cnt_q <= '0;
                jj_q  <= '0;
                st_q  <= (rank_q == '0) ? S_PIVOT : S_ELIM;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          S_ELIM: begin
            nrow_q <= elim_row;
            if (RW'(jj_q) == rank_q - 1'b1) st_q <= S_PIVOT;
            else jj_q <= jj_q + 1'b1;
          end
          S_PIVOT: begin
            if (!lead_found) begin
              res_valid <= 1'b1;
              res_kept  <= 1'b0;
              st_q      <= S_LOAD;
            end else begin
              nrow_q <= scaled;
              lead_q <= lead_idx;
              st_q   <= S_MERGE;
            end
          end
          S_MERGE: begin
            for (int i = 0; i < N; i++) begin
              if (i < ins_pos) begin
                mat_q[i] <= upd[i];
              end else if (i == ins_pos) begin
                mat_q[i] <= nrow_q;
                piv_q[i] <= lead_q;
              end else if (i <= int'(rank_q)) begin
                mat_q[i] <= upd_sh[i];
                piv_q[i] <= piv_sh[i];
              end
            end
            rank_q    <= rank_q + 1'b1;
            res_valid <= 1'b1;
            res_kept  <= 1'b1;
            st_q      <= S_LOAD;
          end
          default: st_q <= S_LOAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/gjd_decoder_chk.sv
module gjd_decoder_chk #(
  parameter int N = 4,
  localparam int RW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          in_ready,
  input logic          res_valid,
  input logic          res_kept,
  input logic [RW-1:0] rank,
  input logic          done
);
  p_rank_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rank <= RW'(N));

  p_keep_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kept) |-> (rank == RW'($past(rank) + 1'b1)));

  p_drop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_kept) |-> (rank == $past(rank)));

  p_busy_before_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$past(in_ready));

  p_done_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rank == '0 && !res_valid));
endmodule

bind gjd_decoder gjd_decoder_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear     (clear),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_kept  (res_kept),
  .rank      (rank),
  .done      (done)
);

// File: tb/gjd_decoder_tb.sv
`timescale 1ns/1ps
module gjd_decoder_tb;
  localparam int N  = 4;
  localparam int K  = 16;
  localparam int W  = N + K;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          res_valid;
  logic          res_kept;
  logic [RW-1:0] rank;
  logic          done;
  logic [IW-1:0] rd_row = '0;
  logic [CW-1:0] rd_col = '0;
  logic [7:0]    rd_data;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  gjd_decoder #(.N(N), .K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .res_valid(res_valid), .res_kept(res_kept), .rank(rank), .done(done),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  logic [7:0] blk [N][K];
  logic [7:0] rowb [W];
  logic [7:0] snap [2][W];

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (a[i]) p = p ^ (16'(b) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11D << (i - 8));
    return p[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int r, input int c, output logic [7:0] v);
    rd_row = IW'(r);
    rd_col = CW'(c);
    #1;
    v = rd_data;
  endtask

  // Vandermonde row r: coef[c] = (r+2)^c, payload = sum coef*blk
  task automatic mk_vrow(input int r);
    logic [7:0] a;
    logic [7:0] p;
    a = 8'(r + 2);
    p = 8'h01;
    for (int c = 0; c < N; c++) begin
      rowb[c] = p;
      p = gmul(p, a);
    end
    for (int b = 0; b < K; b++) begin
      rowb[N+b] = '0;
      for (int c = 0; c < N; c++) rowb[N+b] = rowb[N+b] ^ gmul(rowb[c], blk[c][b]);
    end
  endtask

  task automatic send_row();
    for (int b = 0; b < W; b++) begin
      in_data  = rowb[b];
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic get_result(output bit kept);
    int n = 0;
    kept = 1'b0;
    while (!res_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(res_valid, "R3 result pulse", int'(res_valid), 1);
    kept = res_kept;
    @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic check_rref(input string tag);
    int last = -1;
    logic [7:0] v;
    for (int i = 0; i < int'(rank); i++) begin
      int lc = -1;
      for (int c = N - 1; c >= 0; c--) begin
        rd(i, c, v);
        if (v != 0) lc = c;
      end
      chk(lc > last, tag, lc, last + 1);
      if (lc >= 0) begin
        rd(i, lc, v);
        chk(v == 8'h01, tag, v, 1);
        for (int j = 0; j < int'(rank); j++) if (j != i) begin
          rd(j, lc, v);
          chk(v == 8'h00, tag, v, 0);
        end
      end
      last = lc;
    end
  endtask

  task automatic check_decoded(input string tag);
    logic [7:0] v;
    chk(done == 1'b1, tag, done, 1);
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < N; c++) begin
        rd(i, c, v);
        chk(v == ((i == c) ? 8'h01 : 8'h00), tag, v, (i == c) ? 1 : 0);
      end
      for (int b = 0; b < K; b++) begin
        rd(i, N + b, v);
        chk(v == blk[i][b], tag, v, blk[i][b]);
      end
    end
  endtask

  task automatic t_reset();
    chk(rank == 0, "R9 rank", rank, 0);
    chk(done == 0, "R9 done", done, 0);
    chk(res_valid == 0, "R9 res_valid", res_valid, 0);
    chk(in_ready == 1, "R9 ready", in_ready, 1);
  endtask

  task automatic t_dense();
    bit kept;
    do_clear();
    for (int r = 0; r < N; r++) begin
      mk_vrow(r);
      send_row();
      chk(in_ready == 0, "R2 busy after last byte", in_ready, 0);
      get_result(kept);
      chk(kept == 1, "R3 kept", kept, 1);
      chk(rank == RW'(r + 1), "R3 rank", rank, r + 1);
      check_rref("R5 rref");
    end
    check_decoded("R1 R6 dense decode");
  endtask

  task automatic t_permuted();
    bit kept;
    logic [7:0] v;
    int order [N] = '{3, 1, 0, 2};
    do_clear();
    for (int n = 0; n < N; n++) begin
      int i = order[n];
      logic [7:0] s = 8'(i + 3);
      for (int c = 0; c < N; c++) rowb[c] = (c == i) ? s : 8'h00;
      for (int b = 0; b < K; b++) rowb[N+b] = gmul(s, blk[i][b]);
      send_row();
      get_result(kept);
      chk(kept == 1, "R10 kept", kept, 1);
      if (n == 0) begin
        rd(0, 3, v);
        chk(v == 8'h01, "R10 first row scaled", v, 1);
        rd(0, N + 5, v);
        chk(v == blk[3][5], "R10 first row payload", v, blk[3][5]);
      end
    end
    check_decoded("R10 R6 permuted decode");
  endtask

  task automatic t_dependent();
    bit kept;
    logic [7:0] v;
    logic [7:0] r0 [W];
    do_clear();
    for (int r = 0; r < 2; r++) begin
      mk_vrow(r);
      send_row();
      get_result(kept);
    end
    for (int i = 0; i < 2; i++)
      for (int c = 0; c < W; c++) begin
        rd(i, c, v);
        snap[i][c] = v;
      end
    mk_vrow(0);
    for (int c = 0; c < W; c++) r0[c] = rowb[c];
    mk_vrow(1);
    for (int c = 0; c < W; c++) rowb[c] = r0[c] ^ gmul(8'h07, rowb[c]);
    send_row();
    get_result(kept);
    chk(kept == 0, "R4 combination dropped", kept, 0);
    for (int c = 0; c < W; c++) rowb[c] = (c < N) ? 8'h00 : 8'(c * 9 + 1);
    send_row();
    get_result(kept);
    chk(kept == 0, "R4 zero row dropped", kept, 0);
    chk(rank == 2, "R4 rank held", rank, 2);
    for (int i = 0; i < 2; i++)
      for (int c = 0; c < W; c++) begin
        rd(i, c, v);
        chk(v == snap[i][c], "R4 store unchanged", v, snap[i][c]);
      end
    for (int r = 2; r < N; r++) begin
      mk_vrow(r);
      send_row();
      get_result(kept);
      chk(kept == 1, "R3 kept after drops", kept, 1);
    end
    check_decoded("R6 decode after drops");
  endtask

  task automatic t_done_refuse();
    logic [7:0] v;
    in_valid = 1'b1;
    in_data  = 8'h5A;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      chk(in_ready == 0, "R7 ready low when done", in_ready, 0);
    end
    in_valid = 1'b0;
    chk(rank == RW'(N), "R7 rank held", rank, N);
    check_decoded("R7 store unchanged");
    rd(0, N, v);
    chk(v == blk[0][0], "R7 payload", v, blk[0][0]);
  endtask

  task automatic t_clear_collision();
    bit kept;
    do_clear();
    chk(rank == 0 && done == 0 && in_ready == 1, "R8 plain clear", int'(rank), 0);
    for (int r = 0; r < N - 1; r++) begin
      mk_vrow(r);
      send_row();
      get_result(kept);
    end
    mk_vrow(N - 1);
    send_row();
    // merge edge is rank+2 edges after the last byte
    repeat (N) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(rank == 0, "R8 clear beats merge rank", rank, 0);
    chk(done == 0, "R8 clear beats merge done", done, 0);
    chk(res_valid == 0, "R8 no result pulse", res_valid, 0);
    chk(in_ready == 1, "R8 ready after clear", in_ready, 1);
    mk_vrow(2);
    send_row();
    get_result(kept);
    chk(kept == 1 && rank == 1, "R8 fresh start", int'(rank), 1);
  endtask

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++)
      for (int b = 0; b < K; b++) blk[i][b] = 8'(i * 71 + b * 13 + 29);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dense();
    t_done_refuse();
    t_permuted();
    t_dependent();
    t_clear_collision();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule